// File: doc/BRIEF.md
# Retired Jump Type Classifier

This block sits between a hart's retirement stage and an instruction trace encoder. For each retirement it turns an already decoded opcode class, the destination and source register indices, a branch-taken flag and the trap flags into the trace instruction-type code. Jumps are sorted by how they use the link registers x1 and x5 into calls, tail-calls, returns, co-routine swaps and other jumps. Each kind is also marked inferable (the target is a constant in the opcode) or uninferable (the target comes from a register).

The block also tracks one piece of history: whether the last retirement was a constant-producing instruction (auipc, lui or c.lui) and which register it wrote. An uninferable jump that reads that register on the very next retirement is flagged as sequentially inferable, so the encoder may treat it as inferable. A parameter selects a reduced 3-bit code space, where all uninferable jumps share one code. A second parameter removes the sequential-inference logic for harts that cannot support it.

The outputs are combinational from the current inputs and the stored history. The history register advances on the rising clock edge of every cycle that carries a retirement or a trap.

Top module: `jump_type_classifier`

## Requirements
- R1: When `exc` is high, `itype` is 1 and `sijump` is 0, whatever the other inputs are. When `irq` is high and `exc` is low, `itype` is 2 and `sijump` is 0.
- R2: `op_class` is encoded as 0 plain, 1 jal, 2 jalr, 3 c.jal, 4 c.jalr, 5 c.j, 6 c.jr, 7 conditional branch, 8 trap return, 9 auipc, 10 lui, 11 c.lui. Codes 12 to 15 are treated as plain. With `retire_valid`, `exc` and `irq` all low, `itype` is 0 and `sijump` is 0.
- R3: A retired branch gives 5 when `br_taken` is 1 and 4 when it is 0. A trap return gives 3. Plain, auipc, lui and c.lui retirements give 0.
- R4: jal with rd x1 or x5 gives 9, jal with rd x0 gives 11, and jal with any other rd gives 15. c.jal gives 9 and c.j gives 11.
- R5: jalr with rd x1 and rs other than x5, or with rd x5 and rs other than x1, gives 8. c.jalr with rs other than x5 gives 8.
- R6: jalr x1,x5 and jalr x5,x1 give 12. c.jalr with rs x5 gives 12.
- R7: jalr with rs x1 or x5 and rd neither x1 nor x5 gives 13. c.jr with rs x1 or x5 gives 13.
- R8: jalr x0 with rs neither x1 nor x5 gives 10, and so does c.jr with such an rs. jalr with rd and rs both outside {x0, x1, x5} (rs may be x0) gives 14.
- R9: In 4-bit mode, `sijump` is 1 when three conditions hold: the code is 8, 10, 12 or 14; the previous retirement was auipc, lui or c.lui without a trap; and that retirement's rd equals the jump's rs. Cycles with no retirement and no trap keep the history.
- R10: Any retirement of another kind, or a trap, clears the history. A retirement whose rd does not match, a return (13) or an inferable jump gives `sijump` 0.
- R11: Reset clears the history, so the first jump after reset has `sijump` 0.
- R12: With `ITYPE_W` = 3, every uninferable jump (including returns) gives 6, inferable jumps give 0, other codes are as in 4-bit mode, and 7 never appears. `sijump` follows R9 with code 6 as the only eligible code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; history advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| op_class | input | 4 | Decoded opcode class (encoding in R2) |
| rd | input | REG_W | Destination register index |
| rs | input | REG_W | Source register index (rs1) |
| br_taken | input | 1 | Branch outcome, 1 when taken |
| exc | input | 1 | Exception trap after this retirement |
| irq | input | 1 | Interrupt trap after this retirement |
| itype | output | 4 | Trace instruction-type code |
| sijump | output | 1 | Jump is sequentially inferable |

## Verification
The checker confirms on every cycle the properties that depend only on the current inputs. These are trap priority, the idle code, the branch codes and the absence of code 7. It also checks that a raised `sijump` always comes with an eligible code and that the retirement before it was a constant load. The link-register classification tables, the history being kept across idle cycles and cleared by traps, other retirements and reset, and the reduced-width mapping are shown only by the bench's directed retirement sequences. These sequences run on both a 4-bit and a 3-bit instance.

// File: rtl/jump_type_classifier.sv
module jump_type_classifier #(
  parameter int ITYPE_W   = 4,
  parameter int REG_W     = 5,
  parameter bit SEQ_INFER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_valid,
  input  logic [3:0]       op_class,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs,
  input  logic             br_taken,
  input  logic             exc,
  input  logic             irq,
  output logic [3:0]       itype,
  output logic             sijump
);

  localparam logic [3:0] OP_JAL = 4'd1, OP_JALR = 4'd2, OP_CJAL = 4'd3, OP_CJALR = 4'd4;
  localparam logic [3:0] OP_CJ = 4'd5, OP_CJR = 4'd6, OP_BR = 4'd7, OP_XRET = 4'd8;
  localparam logic [3:0] OP_AUIPC = 4'd9, OP_LUI = 4'd10, OP_CLUI = 4'd11;

  localparam logic [3:0] T_NONE = 4'd0, T_EXC = 4'd1, T_IRQ = 4'd2, T_XRET = 4'd3;
  localparam logic [3:0] T_BNT = 4'd4, T_BT = 4'd5, T_UNINF = 4'd6;
  localparam logic [3:0] T_UCALL = 4'd8, T_ICALL = 4'd9, T_UTAIL = 4'd10, T_ITAIL = 4'd11;
  localparam logic [3:0] T_SWAP = 4'd12, T_RET = 4'd13, T_UOTH = 4'd14, T_IOTH = 4'd15;

  localparam logic [REG_W-1:0] X0 = '0;
  localparam logic [REG_W-1:0] X1 = REG_W'(1);
  localparam logic [REG_W-1:0] X5 = REG_W'(5);

  logic rd_link, rs_link, rd_zero, trap, retire_ok;
  assign rd_link   = (rd == X1) || (rd == X5);
  assign rs_link   = (rs == X1) || (rs == X5);
  assign rd_zero   = (rd == X0);
  assign trap      = exc || irq;
  assign retire_ok = retire_valid && !trap;

  logic [3:0] jalr_code;
  always_comb begin
    if ((rd == X1 && rs == X5) || (rd == X5 && rs == X1)) jalr_code = T_SWAP;
    else if (rd_link)                                      jalr_code = T_UCALL;
    else if (rs_link)                                      jalr_code = T_RET;
    else if (rd_zero)                                      jalr_code = T_UTAIL;
    else                                                   jalr_code = T_UOTH;
  end

  logic [3:0] full_code;
  always_comb begin
    full_code = T_NONE;
    if (exc)
      full_code = T_EXC;
    else if (irq)
      full_code = T_IRQ;
    else if (retire_valid) begin
      case (op_class)
        OP_JAL:   full_code = rd_link ? T_ICALL : (rd_zero ? T_ITAIL : T_IOTH);
        OP_JALR:  full_code = jalr_code;
        OP_CJAL:  full_code = T_ICALL;
        OP_CJALR: full_code = (rs == X5) ? T_SWAP : T_UCALL;
        OP_CJ:    full_code = T_ITAIL;
        OP_CJR:   full_code = rs_link ? T_RET : T_UTAIL;
        OP_BR:    full_code = br_taken ? T_BT : T_BNT;
        OP_XRET:  full_code = T_XRET;
        default:  full_code = T_NONE;
      endcase
    end
  end

  logic uninf, inf_jump;
  assign uninf    = (full_code == T_UCALL) || (full_code == T_UTAIL) || (full_code == T_SWAP) ||
                    (full_code == T_RET)   || (full_code == T_UOTH);
  assign inf_jump = (full_code == T_ICALL) || (full_code == T_ITAIL) || (full_code == T_IOTH);

  logic sij_eligible;
  generate
    if (ITYPE_W == 3) begin : g_narrow
      assign itype        = uninf ? T_UNINF : (inf_jump ? T_NONE : full_code);
      assign sij_eligible = uninf;
    end else begin : g_wide
      assign itype        = full_code;
      assign sij_eligible = uninf && (full_code != T_RET);
    end
  endgenerate

  logic             const_load;
  logic             hist_ok;
  logic [REG_W-1:0] hist_rd;
  assign const_load = (op_class == OP_AUIPC) || (op_class == OP_LUI) || (op_class == OP_CLUI);

  generate
    if (SEQ_INFER) begin : g_seq
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_ok <= 1'b0;
          hist_rd <= '0;
        end else if (retire_valid || trap) begin
          hist_ok <= retire_ok && const_load;
          hist_rd <= rd;
        end
      end
      assign sijump = retire_ok && sij_eligible && hist_ok && (hist_rd == rs);
    end else begin : g_noseq
      assign hist_ok = 1'b0;
      assign hist_rd = '0;
      assign sijump  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/jump_type_classifier_chk.sv
module jump_type_classifier_chk #(
  parameter int ITYPE_W = 4,
  parameter int REG_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire_valid,
  input logic [3:0]       op_class,
  input logic [REG_W-1:0] rd,
  input logic [REG_W-1:0] rs,
  input logic             br_taken,
  input logic             exc,
  input logic             irq,
  input logic [3:0]       itype,
  input logic             sijump
);

  logic prev_load;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prev_load <= 1'b0;
    else if (retire_valid || exc || irq)
      prev_load <= retire_valid && !exc && !irq && (op_class >= 4'd9) && (op_class <= 4'd11);
  end

  a_r1_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (itype == 4'd1 && !sijump));

  a_r1_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !exc) |-> (itype == 4'd2 && !sijump));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_valid && !exc && !irq) |-> (itype == 4'd0 && !sijump));

  a_r3_branch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !exc && !irq && op_class == 4'd7) |-> (itype == (br_taken ? 4'd5 : 4'd4)));

  a_r9_sij_code: assert property (@(posedge clk) disable iff (!rst_n)
    sijump |-> ((ITYPE_W == 3) ? (itype == 4'd6) :
                (itype == 4'd8 || itype == 4'd10 || itype == 4'd12 || itype == 4'd14)));

  a_r10_sij_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    sijump |-> prev_load);

  a_r12_no_seven: assert property (@(posedge clk) disable iff (!rst_n)
    (itype != 4'd7) && ((ITYPE_W != 3) || (itype <= 4'd6)));

endmodule

bind jump_type_classifier jump_type_classifier_chk #(.ITYPE_W(ITYPE_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .op_class(op_class),
  .rd(rd), .rs(rs), .br_taken(br_taken), .exc(exc), .irq(irq),
  .itype(itype), .sijump(sijump)
);

// File: tb/tb_jump_type_classifier.sv
module tb_jump_type_classifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       retire_valid = 1'b0;
  logic [3:0] op_class = '0;
  logic [4:0] rd = '0, rs = '0;
  logic       br_taken = 1'b0, exc = 1'b0, irq = 1'b0;
  logic [3:0] itype, itype3;
  logic       sijump, sijump3;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  localparam logic [3:0] PLAIN = 0, JAL = 1, JALR = 2, CJAL = 3, CJALR = 4, CJ = 5, CJR = 6;
  localparam logic [3:0] BR = 7, XRET = 8, AUIPC = 9, LUI = 10, CLUI = 11;

  always #10 clk = ~clk;

  jump_type_classifier #(.ITYPE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .op_class(op_class),
    .rd(rd), .rs(rs), .br_taken(br_taken), .exc(exc), .irq(irq),
    .itype(itype), .sijump(sijump));

  jump_type_classifier #(.ITYPE_W(3)) dut3 (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .op_class(op_class),
    .rd(rd), .rs(rs), .br_taken(br_taken), .exc(exc), .irq(irq),
    .itype(itype3), .sijump(sijump3));

  function automatic logic [3:0] narrow(input logic [3:0] c);
    if (c == 8 || c == 10 || c == 12 || c == 13 || c == 14) return 4'd6;
    if (c == 9 || c == 11 || c == 15) return 4'd0;
    return c;
  endfunction

  task automatic chk(input string req, input logic [3:0] e4, input logic es4, input logic es3);
    n_chk++;
    if (itype !== e4 || sijump !== es4) begin
      n_bad++;
      $display("FAIL %s 4-bit: itype=%0d sijump=%0b expected itype=%0d sijump=%0b", req, itype, sijump, e4, es4);
    end
    n_chk++;
    if (itype3 !== narrow(e4) || sijump3 !== es3) begin
      n_bad++;
      $display("FAIL %s 3-bit: itype=%0d sijump=%0b expected itype=%0d sijump=%0b", req, itype3, sijump3, narrow(e4), es3);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [4:0] d, input logic [4:0] s,
                      input logic tk, input logic e, input logic i,
                      input string req, input logic [3:0] e4, input logic es4, input logic es3);
    @(negedge clk);
    retire_valid = v; op_class = op; rd = d; rs = s; br_taken = tk; exc = e; irq = i;
    #1;
    chk(req, e4, es4, es3);
  endtask

  task automatic ret(input logic [3:0] op, input logic [4:0] d, input logic [4:0] s,
                     input string req, input logic [3:0] e4, input logic es4 = 0, input logic es3 = 0);
    step(1, op, d, s, 0, 0, 0, req, e4, es4, es3);
  endtask

  task automatic idle(input string req);
    step(0, PLAIN, 0, 0, 0, 0, 0, req, 0, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; retire_valid = 0; exc = 0; irq = 0;
    #1; chk("R11 reset idle", 0, 0, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_traps();
    step(1, JALR, 0, 6, 0, 1, 0, "R1 exc over jump", 1, 0, 0);
    step(0, PLAIN, 0, 0, 0, 0, 1, "R1 irq no retire", 2, 0, 0);
    step(1, BR, 0, 0, 1, 1, 1, "R1 exc over irq", 1, 0, 0);
    step(0, JAL, 1, 0, 0, 0, 0, "R2 idle with op set", 0, 0, 0);
  endtask

  task automatic t_simple();
    step(1, BR, 0, 0, 1, 0, 0, "R3 taken branch", 5, 0, 0);
    step(1, BR, 0, 0, 0, 0, 0, "R3 nontaken branch", 4, 0, 0);
    ret(XRET, 0, 0, "R3 trap return", 3);
    ret(PLAIN, 3, 4, "R3 plain", 0);
    ret(4'd13, 3, 4, "R2 unused class", 0);
    ret(AUIPC, 3, 0, "R3 auipc", 0);
  endtask

  task automatic t_jal();
    ret(JAL, 1, 0, "R4 jal x1", 9);
    ret(JAL, 5, 0, "R4 jal x5", 9);
    ret(JAL, 0, 0, "R4 jal x0", 11);
    ret(JAL, 7, 0, "R4 jal x7", 15);
    ret(CJAL, 0, 0, "R4 c.jal", 9);
    ret(CJ, 0, 0, "R4 c.j", 11);
  endtask

  task automatic t_calls_swaps();
    ret(JALR, 1, 6, "R5 jalr x1,x6", 8);
    ret(JALR, 1, 1, "R5 jalr x1,x1", 8);
    ret(JALR, 5, 5, "R5 jalr x5,x5", 8);
    ret(CJALR, 1, 6, "R5 c.jalr x6", 8);
    ret(CJALR, 1, 1, "R5 c.jalr x1", 8);
    ret(JALR, 1, 5, "R6 jalr x1,x5", 12);
    ret(JALR, 5, 1, "R6 jalr x5,x1", 12);
    ret(CJALR, 1, 5, "R6 c.jalr x5", 12);
  endtask

  task automatic t_ret_tail_other();
    ret(JALR, 0, 1, "R7 jalr x0,x1", 13);
    ret(JALR, 7, 5, "R7 jalr x7,x5", 13);
    ret(CJR, 0, 1, "R7 c.jr x1", 13);
    ret(CJR, 0, 5, "R7 c.jr x5", 13);
    ret(JALR, 0, 6, "R8 jalr x0,x6", 10);
    ret(CJR, 0, 6, "R8 c.jr x6", 10);
    ret(JALR, 7, 6, "R8 jalr x7,x6", 14);
    ret(JALR, 7, 0, "R8 jalr x7,x0", 14);
  endtask

  task automatic t_seq_hit();
    ret(LUI, 6, 0, "R9 lui x6", 0);
    ret(JALR, 0, 6, "R9 tail after lui", 10, 1, 1);
    ret(AUIPC, 7, 0, "R9 auipc x7", 0);
    ret(JALR, 1, 7, "R9 call after auipc", 8, 1, 1);
    ret(CLUI, 9, 0, "R9 c.lui x9", 0);
    idle("R9 idle gap");
    idle("R9 idle gap 2");
    ret(CJR, 0, 9, "R9 c.jr after gap", 10, 1, 1);
    ret(AUIPC, 5, 0, "R9 auipc x5", 0);
    ret(CJALR, 1, 5, "R9 swap after auipc", 12, 1, 1);
    ret(LUI, 8, 0, "R9 lui x8", 0);
    ret(JALR, 7, 8, "R9 other after lui", 14, 1, 1);
  endtask

  task automatic t_seq_miss();
    ret(LUI, 6, 0, "R10 lui x6", 0);
    ret(JALR, 0, 7, "R10 rd mismatch", 10, 0, 0);
    ret(LUI, 6, 0, "R10 lui x6", 0);
    ret(PLAIN, 2, 0, "R10 intervening", 0);
    ret(JALR, 0, 6, "R10 after intervening", 10, 0, 0);
    ret(AUIPC, 1, 0, "R10 auipc x1", 0);
    ret(JALR, 0, 1, "R10 return no sij 4-bit", 13, 0, 1);
    ret(LUI, 6, 0, "R10 lui x6", 0);
    ret(JAL, 0, 6, "R10 inferable", 11, 0, 0);
    step(1, LUI, 6, 0, 0, 1, 0, "R10 lui with exc", 1, 0, 0);
    ret(JALR, 0, 6, "R10 after trap", 10, 0, 0);
    ret(LUI, 6, 0, "R10 lui x6", 0);
    step(0, PLAIN, 0, 0, 0, 0, 1, "R10 irq only", 2, 0, 0);
    ret(JALR, 0, 6, "R10 after irq", 10, 0, 0);
  endtask

  task automatic t_reset_hist();
    ret(LUI, 6, 0, "R11 lui before reset", 0);
    t_reset();
    ret(JALR, 0, 6, "R11 jump after reset", 10, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1; chk("R11 in reset", 0, 0, 0);
    @(negedge clk); @(negedge clk); rst_n = 1;
    t_traps();
    t_simple();
    t_jal();
    t_calls_swaps();
    t_ret_tail_other();
    t_seq_hit();
    t_seq_miss();
    t_reset_hist();
    idle("R2 final idle");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule